// File: doc/BRIEF.md
# Predicated Vector Compare Unit

This block turns a compare instruction into an element-wise operation over a vector of operands. Rather than resolving a branch, it evaluates the selected relation once per element and builds a predicate bitmask. Bit i of that mask holds the outcome for element i. The decode covers two instruction families. The integer branch codes give equality, signed and unsigned orderings. The floating-point compare codes give equal, not-equal, less-than and less-or-equal.

Each side of the compare is either a vector or a scalar. The unit presents an element index on `elem_idx`, and the register file answers combinationally on `elem_a` and `elem_b`. A scalar side is captured from `scal_a` or `scal_b` when the operation starts, and that value is reused against every element. If neither side is a vector, the unit behaves as the ordinary scalar instruction. It reports one flag and writes no mask.

An optional input predicate suppresses individual elements. Floating-point values are compared on their raw sign-magnitude encodings; there is no arithmetic core.

Top module: `pred_cmp_unit`

## Requirements
- R1: With `is_fp`=0, `funct3` selects the integer relation: 000 equal, 001 not equal, 100 signed a<=b, 101 signed a>=b, 110 unsigned a<b, 111 unsigned a>=b. All compares use the full ELEN-bit operands.
- R2: With `is_fp`=0, a `funct3` of 010 or 011 raises `illegal` together with a one-cycle `done` on the cycle after start. No mask is written (`mask_we` stays 0).
- R3: With `is_fp`=1, `funct3` selects 010 equal, 011 not equal, 001 a<b and 000 a<=b. `fmt` 00 compares the low 32 bits, `fmt` 01 the low 64 bits and `fmt` 11 all ELEN bits. A `fmt` of 10, or a `funct3` of 1xx, raises `illegal` as in R2.
- R4: Floating-point ordering treats the top compared bit as the sign and the rest as the magnitude. Any negative value is below any non-negative one (so -0 < +0). Among negatives, the larger magnitude is lower. Equality is bit-exact over the compared bits.
- R5: When neither `src1_vec` nor `src2_vec` is set, `done` pulses on the cycle after start. `scalar_flag` then holds the relation on `scal_a`, `scal_b`, and `mask_we` stays 0.
- R6: A side whose vector flag is clear uses the value on its scalar input, as captured at start, for every element. A side whose flag is set uses `elem_a` / `elem_b`.
- R7: A vector operation with effective length L>0 visits elements 0 to L-1 on consecutive cycles, one per cycle, beginning the cycle after start. `busy` is high throughout, and start is ignored while `busy` is high.
- R8: When `pmask_en` is 1 and bit i of `pmask` (captured at start) is 0, result bit i is 0.
- R9: The effective length is `vl` clamped to XLEN. Result bits at or above it are 0. A length of 0 gives an all-zero mask with `done` on the cycle after start.
- R10: `done` is high for exactly one cycle, namely the cycle in which the result is valid: L+1 cycles after the start edge for a vector operation, 1 otherwise. `mask_we` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| is_fp | input | 1 | 1 selects the floating-point compare family |
| funct3 | input | 3 | Relation code |
| fmt | input | 2 | Floating-point format code |
| src1_vec | input | 1 | First source is a vector |
| src2_vec | input | 1 | Second source is a vector |
| vl | input | $clog2(XLEN+1) | Requested element count |
| pmask_en | input | 1 | Apply the input predicate |
| pmask | input | XLEN | Input predicate, bit per element |
| scal_a | input | ELEN | First source scalar value |
| scal_b | input | ELEN | Second source scalar value |
| elem_a | input | ELEN | First source element at `elem_idx` |
| elem_b | input | ELEN | Second source element at `elem_idx` |
| busy | output | 1 | Element loop in progress |
| elem_idx | output | $clog2(XLEN) | Element currently evaluated |
| done | output | 1 | Result valid, one-cycle pulse |
| mask_we | output | 1 | Predicate destination must be written |
| mask_out | output | XLEN | Result bitmask |
| scalar_flag | output | 1 | Result of a scalar-scalar compare |
| illegal | output | 1 | Last operation had a reserved encoding |

## Verification
The bench targets the signed-versus-unsigned boundary with operands whose top bit differs. A design that mixed up the two orderings would invert those results. For floating-point it uses opposite-signed zeros, negative pairs, and garbage above bit 31 in single format. A plain unsigned compare, or a compare over the wrong width, would flip bits there. It also runs lengths of 0, exactly XLEN and above XLEN, reserved codes, and scalar-only compares. These expose an off-by-one loop, stray bits past the length, a write on an illegal code, or a mask written for a scalar instruction. Predicate masks with holes and scalar reuse on either side catch a design that ignores the mask or swaps the operands.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [3:0] {
    OP_EQ,
    OP_NE,
    OP_LES,
    OP_GES,
    OP_LTU,
    OP_GEU,
    OP_FEQ,
    OP_FNE,
    OP_FLT,
    OP_FLE
  } cmp_op_e;

  // floating-point format codes
  localparam logic [1:0] FMT_S = 2'b00;
  localparam logic [1:0] FMT_D = 2'b01;
  localparam logic [1:0] FMT_Q = 2'b11;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
(
  input  logic       is_fp,
  input  logic [2:0] funct3,
  input  logic [1:0] fmt,
  output cmp_op_e    op,
  output logic       bad
);

  always_comb begin
    op  = OP_EQ;
    bad = 1'b0;
    if (!is_fp) begin
      unique case (funct3)
        3'b000: op = OP_EQ;
        3'b001: op = OP_NE;
        3'b100: op = OP_LES;
        3'b101: op = OP_GES;
        3'b110: op = OP_LTU;
        3'b111: op = OP_GEU;
        default: bad = 1'b1;
      endcase
    end else begin
      unique case (funct3)
        3'b010: op = OP_FEQ;
        3'b011: op = OP_FNE;
        3'b001: op = OP_FLT;
        3'b000: op = OP_FLE;
        default: bad = 1'b1;
      endcase
      if (fmt != FMT_S && fmt != FMT_D && fmt != FMT_Q) bad = 1'b1;
    end
  end

endmodule

// File: rtl/pcu_elem_cmp.sv
module pcu_elem_cmp
  import pcu_pkg::*;
#(
  parameter int ELEN = 64
) (
  input  cmp_op_e         op,
  input  logic [1:0]      fmt,
  input  logic [ELEN-1:0] a,
  input  logic [ELEN-1:0] b,
  output logic            hit
);

  localparam int WD = (ELEN < 64) ? ELEN : 64;
  localparam int WS = (ELEN < 32) ? ELEN : 32;

  function automatic int fp_width(input logic [1:0] f);
    if (f == FMT_S)      return WS;
    else if (f == FMT_D) return WD;
    else                 return ELEN;
  endfunction

  // sign-magnitude encoding remapped to an unsigned-ordered key
  function automatic logic [ELEN-1:0] fp_key(input logic [ELEN-1:0] x, input int w);
    logic [ELEN-1:0] lm, xm, sb;
    lm = (ELEN'(1) << w) - ELEN'(1);
    if (w >= ELEN) lm = '1;
    sb = ELEN'(1) << (w - 1);
    xm = x & lm;
    return ((xm & sb) != '0) ? (~xm & lm) : (xm | sb);
  endfunction

  logic [ELEN-1:0] ka, kb;
  int              w;

  always_comb begin
    w  = fp_width(fmt);
    ka = fp_key(a, w);
    kb = fp_key(b, w);
    unique case (op)
      OP_EQ:  hit = (a == b);
      OP_NE:  hit = (a != b);
      OP_LES: hit = ($signed(a) <= $signed(b));
      OP_GES: hit = ($signed(a) >= $signed(b));
      OP_LTU: hit = (a < b);
      OP_GEU: hit = (a >= b);
      OP_FEQ: hit = (ka == kb);
      OP_FNE: hit = (ka != kb);
      OP_FLT: hit = (ka < kb);
      OP_FLE: hit = (ka <= kb);
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcu_seq.sv
module pcu_seq #(
  parameter int XLEN = 64,
  localparam int IW = $clog2(XLEN),
  localparam int VW = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            bad_in,
  input  logic            is_vec,
  input  logic [VW-1:0]   vl_in,
  input  logic            pmen_in,
  input  logic [XLEN-1:0] pm_in,
  input  logic            hit,
  output logic            busy,
  output logic [IW-1:0]   idx,
  output logic            done,
  output logic            mask_we,
  output logic [XLEN-1:0] mask,
  output logic            scalar_flag,
  output logic            bad,
  output logic [VW-1:0]   vl_q,
  output logic            pmen_q,
  output logic [XLEN-1:0] pm_q,
  output logic            accept,
  output logic            keep_bit,
  output logic            last_elem
);

  logic [VW-1:0] vl_clamp;

  assign vl_clamp  = (vl_in > VW'(XLEN)) ? VW'(XLEN) : vl_in;
  assign accept    = start && !busy;
  assign keep_bit  = hit && (!pmen_q || pm_q[idx]);
  assign last_elem = busy && (VW'(idx) == vl_q - VW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      idx         <= '0;
      done        <= 1'b0;
      mask_we     <= 1'b0;
      mask        <= '0;
      scalar_flag <= 1'b0;
      bad         <= 1'b0;
      vl_q        <= '0;
      pmen_q      <= 1'b0;
      pm_q        <= '0;
    end else begin
      done    <= 1'b0;
      mask_we <= 1'b0;
      if (accept) begin
        bad         <= bad_in;
        scalar_flag <= 1'b0;
        mask        <= '0;
        idx         <= '0;
        if (bad_in) begin
          done <= 1'b1;
        end else if (!is_vec) begin
          done        <= 1'b1;
          scalar_flag <= hit;
        end else begin
          vl_q   <= vl_clamp;
          pmen_q <= pmen_in;
          pm_q   <= pm_in;
          if (vl_clamp == '0) begin
            done    <= 1'b1;
            mask_we <= 1'b1;
          end else begin
            busy <= 1'b1;
          end
        end
      end else if (busy) begin
        mask[idx] <= keep_bit;
        if (last_elem) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          mask_we <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
  import pcu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int ELEN = 64,
  localparam int IW = $clog2(XLEN),
  localparam int VW = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_fp,
  input  logic [2:0]      funct3,
  input  logic [1:0]      fmt,
  input  logic            src1_vec,
  input  logic            src2_vec,
  input  logic [VW-1:0]   vl,
  input  logic            pmask_en,
  input  logic [XLEN-1:0] pmask,
  input  logic [ELEN-1:0] scal_a,
  input  logic [ELEN-1:0] scal_b,
  input  logic [ELEN-1:0] elem_a,
  input  logic [ELEN-1:0] elem_b,
  output logic            busy,
  output logic [IW-1:0]   elem_idx,
  output logic            done,
  output logic            mask_we,
  output logic [XLEN-1:0] mask_out,
  output logic            scalar_flag,
  output logic            illegal
);

  cmp_op_e         op_now, op_q, op_use;
  logic            bad_now;
  logic [1:0]      fmt_q, fmt_use;
  logic [ELEN-1:0] sa_q, sb_q, opa, opb;
  logic            s1v_q, s2v_q, hit;
  logic [VW-1:0]   vl_q;
  logic            pmen_q;
  logic [XLEN-1:0] pm_q;
  logic            accept, keep_bit, last_elem;

  pcu_decode u_dec (
    .is_fp  (is_fp),
    .funct3 (funct3),
    .fmt    (fmt),
    .op     (op_now),
    .bad    (bad_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= OP_EQ;
      fmt_q <= '0;
      sa_q  <= '0;
      sb_q  <= '0;
      s1v_q <= 1'b0;
      s2v_q <= 1'b0;
    end else if (accept) begin
      op_q  <= op_now;
      fmt_q <= fmt;
      sa_q  <= scal_a;
      sb_q  <= scal_b;
      s1v_q <= src1_vec;
      s2v_q <= src2_vec;
    end
  end

  // idle: evaluate the live scalars (scalar-only case); busy: latched setup
  always_comb begin
    if (busy) begin
      op_use  = op_q;
      fmt_use = fmt_q;
      opa     = s1v_q ? elem_a : sa_q;
      opb     = s2v_q ? elem_b : sb_q;
    end else begin
      op_use  = op_now;
      fmt_use = fmt;
      opa     = scal_a;
      opb     = scal_b;
    end
  end

  pcu_elem_cmp #(.ELEN(ELEN)) u_cmp (
    .op  (op_use),
    .fmt (fmt_use),
    .a   (opa),
    .b   (opb),
    .hit (hit)
  );

  pcu_seq #(.XLEN(XLEN)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .bad_in      (bad_now),
    .is_vec      (src1_vec || src2_vec),
    .vl_in       (vl),
    .pmen_in     (pmask_en),
    .pm_in       (pmask),
    .hit         (hit),
    .busy        (busy),
    .idx         (elem_idx),
    .done        (done),
    .mask_we     (mask_we),
    .mask        (mask_out),
    .scalar_flag (scalar_flag),
    .bad         (illegal),
    .vl_q        (vl_q),
    .pmen_q      (pmen_q),
    .pm_q        (pm_q),
    .accept      (accept),
    .keep_bit    (keep_bit),
    .last_elem   (last_elem)
  );

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int XLEN = 64,
  localparam int IW = $clog2(XLEN),
  localparam int VW = $clog2(XLEN + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            mask_we,
  input logic            illegal,
  input logic [IW-1:0]   elem_idx,
  input logic [VW-1:0]   vl_q,
  input logic            pmen_q,
  input logic [XLEN-1:0] pm_q,
  input logic [XLEN-1:0] mask_out,
  input logic            last_elem
);

  p_no_write_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && illegal |-> !mask_we);

  p_idx_below_vl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> VW'(elem_idx) < vl_q);

  p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_elem |=> busy && elem_idx == $past(elem_idx) + IW'(1));

  p_last_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    last_elem |=> !busy && done && mask_we);

  p_pred_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we && pmen_q |-> (mask_out & ~pm_q) == '0);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |-> (mask_out >> vl_q) == '0);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_we_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |-> done);

endmodule

bind pred_cmp_unit pcu_checker #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .mask_we   (mask_we),
  .illegal   (illegal),
  .elem_idx  (elem_idx),
  .vl_q      (vl_q),
  .pmen_q    (pmen_q),
  .pm_q      (pm_q),
  .mask_out  (mask_out),
  .last_elem (last_elem)
);

// File: tb/sim_pred_cmp_unit.sv
`timescale 1ns/1ps
module sim_pred_cmp_unit;

  localparam int XLEN = 64;
  localparam int ELEN = 64;
  localparam int IW = $clog2(XLEN);
  localparam int VW = $clog2(XLEN + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0, is_fp = 1'b0, src1_vec = 1'b0, src2_vec = 1'b0, pmask_en = 1'b0;
  logic [2:0]      funct3 = '0;
  logic [1:0]      fmt = '0;
  logic [VW-1:0]   vl = '0;
  logic [XLEN-1:0] pmask = '0;
  logic [ELEN-1:0] scal_a = '0, scal_b = '0, elem_a, elem_b;
  logic            busy, done, mask_we, scalar_flag, illegal;
  logic [IW-1:0]   elem_idx;
  logic [XLEN-1:0] mask_out;

  logic [ELEN-1:0] va [XLEN];
  logic [ELEN-1:0] vb [XLEN];

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always_comb begin
    elem_a = va[elem_idx];
    elem_b = vb[elem_idx];
  end

  pred_cmp_unit #(.XLEN(XLEN), .ELEN(ELEN)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_fp(is_fp), .funct3(funct3), .fmt(fmt),
    .src1_vec(src1_vec), .src2_vec(src2_vec), .vl(vl), .pmask_en(pmask_en), .pmask(pmask),
    .scal_a(scal_a), .scal_b(scal_b), .elem_a(elem_a), .elem_b(elem_b),
    .busy(busy), .elem_idx(elem_idx), .done(done), .mask_we(mask_we), .mask_out(mask_out),
    .scalar_flag(scalar_flag), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------- reference model ----------
  function automatic bit ref_bad(input bit fp, input logic [2:0] f3, input logic [1:0] fm);
    if (!fp) return (f3 == 3'b010 || f3 == 3'b011);
    return (f3[2] == 1'b1) || (fm == 2'b10);
  endfunction

  function automatic bit fp_less(input logic [63:0] x, input logic [63:0] y, input int w);
    bit sx, sy;
    logic [63:0] mx, my;
    sx = x[w-1];
    sy = y[w-1];
    mx = x & ((64'd1 << (w - 1)) - 64'd1);
    my = y & ((64'd1 << (w - 1)) - 64'd1);
    if (sx != sy) return sx;
    if (!sx) return mx < my;
    return mx > my;
  endfunction

  function automatic bit ref_hit(input bit fp, input logic [2:0] f3, input logic [1:0] fm,
                                 input logic [63:0] a, input logic [63:0] b);
    int w;
    logic [63:0] x, y;
    if (!fp) begin
      case (f3)
        3'b000: return a == b;
        3'b001: return a != b;
        3'b100: return $signed(a) <= $signed(b);
        3'b101: return $signed(a) >= $signed(b);
        3'b110: return a < b;
        default: return a >= b;
      endcase
    end
    w = (fm == 2'b00) ? 32 : 64;
    x = (w == 32) ? {32'd0, a[31:0]} : a;
    y = (w == 32) ? {32'd0, b[31:0]} : b;
    case (f3)
      3'b010: return x == y;
      3'b011: return x != y;
      3'b001: return fp_less(x, y, w);
      default: return fp_less(x, y, w) || (x == y);
    endcase
  endfunction

  // ---------- one operation ----------
  task automatic run_op(input string req, input bit fp, input logic [2:0] f3, input logic [1:0] fm,
                        input bit v1, input bit v2, input int n, input bit pen,
                        input logic [XLEN-1:0] pm);
    int lat, eff, exp_lat;
    bit bad, vec;
    logic [XLEN-1:0] exp_mask;
    logic [63:0] ea, eb;
    bad = ref_bad(fp, f3, fm);
    vec = v1 || v2;
    eff = (n > XLEN) ? XLEN : n;
    exp_mask = '0;
    if (!bad && vec)
      for (int i = 0; i < eff; i++) begin
        ea = v1 ? va[i] : scal_a;
        eb = v2 ? vb[i] : scal_b;
        exp_mask[i] = ref_hit(fp, f3, fm, ea, eb) && (!pen || pm[i]);
      end
    exp_lat = (!bad && vec) ? eff + 1 : 1;
    @(negedge clk);
    is_fp = fp; funct3 = f3; fmt = fm; src1_vec = v1; src2_vec = v2;
    vl = VW'(n); pmask_en = pen; pmask = pm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, req, "R10 done latency", 64'(lat), 64'(exp_lat));
    chk(illegal == bad, req, "R2/R3 illegal flag", 64'(illegal), 64'(bad));
    chk(mask_we == (!bad && vec), req, "R5 mask_we", 64'(mask_we), 64'(!bad && vec));
    if (!bad && vec)
      chk(mask_out == exp_mask, req, "mask value", mask_out, exp_mask);
    if (!bad && !vec)
      chk(scalar_flag == ref_hit(fp, f3, fm, scal_a, scal_b), req, "R5 scalar flag",
          64'(scalar_flag), 64'(ref_hit(fp, f3, fm, scal_a, scal_b)));
    @(negedge clk);
    chk(!done, req, "R10 done single cycle", 64'(done), 64'd0);
  endtask

  function automatic logic [63:0] rnd_val();
    case ($urandom % 5)
      0: return 64'h8000_0000_0000_0000;
      1: return {$urandom} & 64'hF;
      2: return 64'(0) - 64'({$urandom} & 64'h7);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic fill_random();
    for (int i = 0; i < XLEN; i++) begin
      va[i] = rnd_val();
      vb[i] = ($urandom % 3 == 0) ? va[i] : rnd_val();
    end
    scal_a = rnd_val();
    scal_b = ($urandom % 3 == 0) ? scal_a : rnd_val();
  endtask

  // ---------- watchdog ----------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------- main ----------
  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < XLEN; i++) begin va[i] = '0; vb[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !mask_we && !illegal && mask_out == '0, "reset", "R10 idle outputs",
        {busy, done, mask_we, illegal}, 64'd0);

    // R1: signed vs unsigned boundary
    for (int i = 0; i < XLEN; i++) begin
      va[i] = (i % 2) ? 64'h8000_0000_0000_0000 : 64'd5;
      vb[i] = (i % 3) ? 64'd5 : 64'hFFFF_FFFF_FFFF_FFFF;
    end
    for (int f = 0; f < 8; f++)
      if (f != 2 && f != 3) run_op("R1 int relation", 0, 3'(f), 2'b00, 1, 1, 20, 0, '0);

    // R2: reserved integer codes
    run_op("R2 reserved 010", 0, 3'b010, 2'b00, 1, 1, 10, 0, '0);
    run_op("R2 reserved 011", 0, 3'b011, 2'b00, 1, 0, 10, 0, '0);

    // R3/R4: fp codes, signed zeros, negatives, single with upper garbage
    va[0] = 64'h0000_0000_8000_0000; vb[0] = 64'h0000_0000_0000_0000;
    va[1] = 64'hDEAD_BEEF_3F80_0000; vb[1] = 64'h1234_5678_3F80_0000;
    va[2] = 64'h0000_0000_C000_0000; vb[2] = 64'h0000_0000_BF80_0000;
    va[3] = 64'h0000_0000_BF80_0000; vb[3] = 64'h0000_0000_3F80_0000;
    va[4] = 64'h0000_0000_4000_0000; vb[4] = 64'h0000_0000_3F80_0000;
    for (int f = 0; f < 4; f++) begin
      run_op("R3 R4 fp single", 1, 3'(f), 2'b00, 1, 1, 5, 0, '0);
      run_op("R3 R4 fp double", 1, 3'(f), 2'b01, 1, 1, 5, 0, '0);
      run_op("R3 fp quad", 1, 3'(f), 2'b11, 1, 1, 5, 0, '0);
    end
    run_op("R3 fmt 10 illegal", 1, 3'b010, 2'b10, 1, 1, 5, 0, '0);
    run_op("R3 fp funct3 1xx illegal", 1, 3'b101, 2'b00, 1, 1, 5, 0, '0);

    // R5: scalar-scalar
    scal_a = 64'hFFFF_FFFF_FFFF_FFFF; scal_b = 64'd1;
    run_op("R5 scalar LE signed", 0, 3'b100, 2'b00, 0, 0, 30, 0, '0);
    run_op("R5 scalar GEU", 0, 3'b111, 2'b00, 0, 0, 30, 0, '0);

    // R6: scalar reuse on each side
    fill_random();
    scal_a = 64'd7; scal_b = 64'd7;
    for (int i = 0; i < XLEN; i++) begin va[i] = 64'(i % 11); vb[i] = 64'(i % 13); end
    run_op("R6 vector-scalar", 0, 3'b100, 2'b00, 1, 0, 40, 0, '0);
    run_op("R6 scalar-vector", 0, 3'b100, 2'b00, 0, 1, 40, 0, '0);

    // R8: predicate holes
    run_op("R8 predicate", 0, 3'b001, 2'b00, 1, 1, 64, 1, 64'hF0F0_0FF0_AAAA_5555);

    // R9: length boundaries
    run_op("R9 vl zero", 0, 3'b000, 2'b00, 1, 1, 0, 0, '0);
    run_op("R9 vl one", 0, 3'b110, 2'b00, 1, 1, 1, 0, '0);
    run_op("R9 vl full", 0, 3'b111, 2'b00, 1, 1, XLEN, 0, '0);
    run_op("R9 vl over", 0, 3'b111, 2'b00, 1, 1, 100, 0, '0);

    // R7: start while busy is ignored
    @(negedge clk);
    is_fp = 0; funct3 = 3'b000; src1_vec = 1; src2_vec = 1; vl = VW'(8); pmask_en = 0; start = 1;
    @(negedge clk);
    funct3 = 3'b010; vl = VW'(2);
    repeat (3) @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    chk(done && !illegal, "R7 start ignored while busy", "done at 9", {done, illegal}, 64'h2);
    @(negedge clk);

    // random mix
    for (int k = 0; k < 150; k++) begin
      bit fp;
      logic [1:0] fm;
      fill_random();
      fp = $urandom % 2;
      fm = ($urandom % 8 == 0) ? 2'b10 : (($urandom % 2) ? 2'b00 : 2'b01);
      run_op("R1 R3 R6 R8 R9 random", fp, 3'($urandom % 8), fm, 1'($urandom % 2),
             1'($urandom % 2), int'($urandom % 80), 1'($urandom % 2), {$urandom, $urandom});
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule